// File: doc/BRIEF.md
# Conditional-Move Splitting Rename Grouper

This front-end stage sits between instruction decode and the register mapper. It accepts a fetch line of `LANES` decoded instructions in one valid/ready transfer. It then hands the mapper one rename group per accepted output transfer. A three-operand conditional move (condition source A, data source B, destination C) cannot pass through a two-operand mapper as it stands. It is therefore split into two chained micro-ops. The first part reads A and the old mapping of C, and writes a fresh copy of C. The second part reads that fresh C and B, and writes C once more. Each part therefore takes a physical register of its own from the free list.

The two halves of one conditional move never share a map cycle. A group always closes right after a first part. The following group opens with the matching second part and then carries on with later instructions in program order. A line holding n conditional moves is therefore emitted as n+1 groups. A line without conditional moves leaves in a single group with its operands unchanged.

Back-pressure rules: an output group is offered while `out_valid` is high. It is held unchanged until a cycle with `out_ready` high takes it. `in_ready` is high only when no line is held. It falls in the cycle after a line is taken. It rises again in the cycle after the final group of that line has been accepted. A line offered while `in_ready` is low is not taken.

Top module: `cmg_grouper`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A line with no valid conditional move is emitted as one group. Its valid lanes fill slots from slot 0 in lane order with kind 0 (plain) and operands unchanged (A, B, C), and marker 0.
- R3: A conditional-move lane first yields a kind 1 micro-op. Its source A is the lane's A, its source B is the lane's C, its destination is C, and its old-mapping marker is 1. No other micro-op kind sets the marker.
- R4: The matching second micro-op has kind 2, source A equal to the lane's C, source B equal to the lane's B, destination C, and marker 0.
- R5: A group ends immediately after a kind 1 micro-op. The next group starts in slot 0 with the matching kind 2 micro-op, followed by later valid lanes in order.
- R6: A line with n valid conditional moves produces exactly n+1 groups. `out_last` is 1 on the final group only, and the final group contains no kind 1 micro-op.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output holds its value into the next cycle.
- R8: `in_ready` falls the cycle after a line is accepted. It stays low while groups of that line remain, and it is 1 again the cycle after the final group is accepted. A line offered while `in_ready` is low has no effect on any group.
- R9: Lanes with lane-valid 0 produce nothing, whatever their other fields. Unused slots carry valid 0, kind 0, all operands 0 and marker 0.
- R10: A line with no valid lane produces one group with no valid slot and `out_last` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch line offered |
| in_ready | output | 1 | Block can take a line |
| in_lane_valid | input | LANES | Per-lane instruction present |
| in_is_cmov | input | LANES | Per-lane conditional-move flag |
| in_src_a | input | LANES*REG_W | Per-lane source A (condition for a conditional move) |
| in_src_b | input | LANES*REG_W | Per-lane source B |
| in_dst | input | LANES*REG_W | Per-lane destination C |
| out_valid | output | 1 | Group offered |
| out_ready | input | 1 | Mapper takes the group |
| out_slot_valid | output | LANES | Slot holds a micro-op |
| out_kind | output | 2*LANES | Per-slot kind: 0 plain, 1 first part, 2 second part |
| out_src_a | output | LANES*REG_W | Per-slot rewritten source A |
| out_src_b | output | LANES*REG_W | Per-slot rewritten source B |
| out_dst | output | LANES*REG_W | Per-slot destination |
| out_b_old_dst | output | LANES | Source B is the old mapping of the destination |
| out_last | output | 1 | Final group of the current line |

## Verification
The hardest case to reach is a continuation group that is stalled downstream while the held line is being offered a competing line. This matters most when the line ends in a conditional move in the last lane, which leaves a group holding only a second part. The bench sweeps every combination of lane-valid and conditional-move masks for a four-lane line. A pseudo-random sequence withdraws `out_ready` on about a quarter of cycles, so stalls fall on every group position. On alternate lines it keeps `in_valid` high with inverted data while groups are draining.

// File: rtl/cmg_pkg.sv
package cmg_pkg;
  typedef enum logic [1:0] {
    UK_PLAIN  = 2'd0,
    UK_FIRST  = 2'd1,
    UK_SECOND = 2'd2
  } uop_kind_e;
endpackage

// File: rtl/cmg_uop_former.sv
// Rewrites one lane into its primary micro-op (plain or first part) and
// the operands of its second part.
module cmg_uop_former #(
  parameter int REG_W = 5
) (
  input  logic             is_cmov,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  input  logic [REG_W-1:0] rc,
  output logic [1:0]       prim_kind,
  output logic [REG_W-1:0] prim_a,
  output logic [REG_W-1:0] prim_b,
  output logic [REG_W-1:0] prim_d,
  output logic             prim_mark,
  output logic [REG_W-1:0] sec_a,
  output logic [REG_W-1:0] sec_b,
  output logic [REG_W-1:0] sec_d
);
  import cmg_pkg::*;

  always_comb begin
    prim_a = ra;
    prim_d = rc;
    if (is_cmov) begin
      prim_kind = UK_FIRST;
      prim_b    = rc;   // old mapping of the destination
      prim_mark = 1'b1;
    end else begin
      prim_kind = UK_PLAIN;
      prim_b    = rb;
      prim_mark = 1'b0;
    end
    // second part reads the freshly written destination and source B
    sec_a = rc;
    sec_b = rb;
    sec_d = rc;
  end
endmodule

// File: rtl/cmg_group_scan.sv
// Builds the current rename group from the held line, the lane cursor and
// the pending-second-part flag.
module cmg_group_scan #(
  parameter int LANES = 4,
  parameter int REG_W = 5,
  parameter int POS_W = 3
) (
  input  logic [LANES-1:0]       lane_valid,
  input  logic [LANES-1:0]       lane_cmov,
  input  logic [LANES*REG_W-1:0] lane_a,
  input  logic [LANES*REG_W-1:0] lane_b,
  input  logic [LANES*REG_W-1:0] lane_c,
  input  logic [POS_W-1:0]       pos,
  input  logic                   pend,
  output logic [LANES-1:0]       slot_valid,
  output logic [2*LANES-1:0]     slot_kind,
  output logic [LANES*REG_W-1:0] slot_a,
  output logic [LANES*REG_W-1:0] slot_b,
  output logic [LANES*REG_W-1:0] slot_d,
  output logic [LANES-1:0]       slot_mark,
  output logic                   grp_last,
  output logic [POS_W-1:0]       nxt_pos,
  output logic                   nxt_pend
);
  import cmg_pkg::*;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [1:0]       pk [LANES];
  logic [REG_W-1:0] pa [LANES];
  logic [REG_W-1:0] pb [LANES];
  logic [REG_W-1:0] pd [LANES];
  logic             pm [LANES];
  logic [REG_W-1:0] sa [LANES];
  logic [REG_W-1:0] sb [LANES];
  logic [REG_W-1:0] sd [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    cmg_uop_former #(.REG_W(REG_W)) u_former (
      .is_cmov  (lane_cmov[j]),
      .ra       (lane_a[j*REG_W +: REG_W]),
      .rb       (lane_b[j*REG_W +: REG_W]),
      .rc       (lane_c[j*REG_W +: REG_W]),
      .prim_kind(pk[j]),
      .prim_a   (pa[j]),
      .prim_b   (pb[j]),
      .prim_d   (pd[j]),
      .prim_mark(pm[j]),
      .sec_a    (sa[j]),
      .sec_b    (sb[j]),
      .sec_d    (sd[j])
    );
  end

  logic             take [LANES];
  logic [IDX_W-1:0] dest [LANES];
  logic [IDX_W:0]   fill;
  logic             stop;

  // lane selection: walk from the cursor, close after a first part
  always_comb begin
    fill     = pend ? (IDX_W+1)'(1) : '0;
    stop     = 1'b0;
    nxt_pos  = POS_W'(LANES);
    nxt_pend = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      take[j] = 1'b0;
      dest[j] = '0;
      if (!stop && (POS_W'(j) >= pos) && lane_valid[j]) begin
        take[j] = 1'b1;
        dest[j] = fill[IDX_W-1:0];
        fill    = fill + (IDX_W+1)'(1);
        if (lane_cmov[j]) begin
          stop     = 1'b1;
          nxt_pos  = POS_W'(j + 1);
          nxt_pend = 1'b1;
        end
      end
    end
    grp_last = !stop;
  end

  // slot steering
  always_comb begin
    slot_valid = '0;
    slot_kind  = '0;
    slot_a     = '0;
    slot_b     = '0;
    slot_d     = '0;
    slot_mark  = '0;
    if (pend) begin
      for (int j = 0; j < LANES; j++) begin
        if (POS_W'(j + 1) == pos) begin
          slot_valid[0]       = 1'b1;
          slot_kind[1:0]      = UK_SECOND;
          slot_a[REG_W-1:0]   = sa[j];
          slot_b[REG_W-1:0]   = sb[j];
          slot_d[REG_W-1:0]   = sd[j];
        end
      end
    end
    for (int s = 0; s < LANES; s++) begin
      for (int j = 0; j < LANES; j++) begin
        if (take[j] && dest[j] == IDX_W'(s)) begin
          slot_valid[s]            = 1'b1;
          slot_kind[2*s +: 2]      = pk[j];
          slot_a[s*REG_W +: REG_W] = pa[j];
          slot_b[s*REG_W +: REG_W] = pb[j];
          slot_d[s*REG_W +: REG_W] = pd[j];
          slot_mark[s]             = pm[j];
        end
      end
    end
  end
endmodule

// File: rtl/cmg_line_seq.sv
// Holds the accepted line and walks the lane cursor group by group.
module cmg_line_seq #(
  parameter int LANES = 4,
  parameter int REG_W = 5,
  parameter int POS_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES-1:0]       in_lane_valid,
  input  logic [LANES-1:0]       in_is_cmov,
  input  logic [LANES*REG_W-1:0] in_src_a,
  input  logic [LANES*REG_W-1:0] in_src_b,
  input  logic [LANES*REG_W-1:0] in_dst,
  output logic                   out_valid,
  input  logic                   out_ready,
  input  logic                   grp_last,
  input  logic [POS_W-1:0]       nxt_pos,
  input  logic                   nxt_pend,
  output logic [LANES-1:0]       line_valid,
  output logic [LANES-1:0]       line_cmov,
  output logic [LANES*REG_W-1:0] line_a,
  output logic [LANES*REG_W-1:0] line_b,
  output logic [LANES*REG_W-1:0] line_c,
  output logic [POS_W-1:0]       pos,
  output logic                   pend
);
  logic busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pos        <= '0;
      pend       <= 1'b0;
      line_valid <= '0;
      line_cmov  <= '0;
      line_a     <= '0;
      line_b     <= '0;
      line_c     <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        busy       <= 1'b1;
        pos        <= '0;
        pend       <= 1'b0;
        line_valid <= in_lane_valid;
        line_cmov  <= in_is_cmov;
        line_a     <= in_src_a;
        line_b     <= in_src_b;
        line_c     <= in_dst;
      end
    end else if (out_ready) begin
      if (grp_last) begin
        busy <= 1'b0;
        pos  <= '0;
        pend <= 1'b0;
      end else begin
        pos  <= nxt_pos;
        pend <= nxt_pend;
      end
    end
  end

  assign in_ready  = !busy;
  assign out_valid = busy;
endmodule

// File: rtl/cmg_grouper.sv
module cmg_grouper #(
  parameter int LANES = 4,
  parameter int REG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES-1:0]       in_lane_valid,
  input  logic [LANES-1:0]       in_is_cmov,
  input  logic [LANES*REG_W-1:0] in_src_a,
  input  logic [LANES*REG_W-1:0] in_src_b,
  input  logic [LANES*REG_W-1:0] in_dst,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES-1:0]       out_slot_valid,
  output logic [2*LANES-1:0]     out_kind,
  output logic [LANES*REG_W-1:0] out_src_a,
  output logic [LANES*REG_W-1:0] out_src_b,
  output logic [LANES*REG_W-1:0] out_dst,
  output logic [LANES-1:0]       out_b_old_dst,
  output logic                   out_last
);
  localparam int POS_W = $clog2(LANES + 1);

  logic [LANES-1:0]       line_valid;
  logic [LANES-1:0]       line_cmov;
  logic [LANES*REG_W-1:0] line_a;
  logic [LANES*REG_W-1:0] line_b;
  logic [LANES*REG_W-1:0] line_c;
  logic [POS_W-1:0]       pos;
  logic                   pend;
  logic [POS_W-1:0]       nxt_pos;
  logic                   nxt_pend;
  logic                   grp_last;

  cmg_line_seq #(.LANES(LANES), .REG_W(REG_W), .POS_W(POS_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_lane_valid(in_lane_valid),
    .in_is_cmov   (in_is_cmov),
    .in_src_a     (in_src_a),
    .in_src_b     (in_src_b),
    .in_dst       (in_dst),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .grp_last     (grp_last),
    .nxt_pos      (nxt_pos),
    .nxt_pend     (nxt_pend),
    .line_valid   (line_valid),
    .line_cmov    (line_cmov),
    .line_a       (line_a),
    .line_b       (line_b),
    .line_c       (line_c),
    .pos          (pos),
    .pend         (pend)
  );

  cmg_group_scan #(.LANES(LANES), .REG_W(REG_W), .POS_W(POS_W)) u_scan (
    .lane_valid(line_valid),
    .lane_cmov (line_cmov),
    .lane_a    (line_a),
    .lane_b    (line_b),
    .lane_c    (line_c),
    .pos       (pos),
    .pend      (pend),
    .slot_valid(out_slot_valid),
    .slot_kind (out_kind),
    .slot_a    (out_src_a),
    .slot_b    (out_src_b),
    .slot_d    (out_dst),
    .slot_mark (out_b_old_dst),
    .grp_last  (grp_last),
    .nxt_pos   (nxt_pos),
    .nxt_pend  (nxt_pend)
  );

  assign out_last = grp_last;
endmodule

// File: rtl/cmg_grouper_chk.sv
module cmg_grouper_chk #(
  parameter int LANES = 4,
  parameter int REG_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [LANES-1:0]       in_lane_valid,
  input logic [LANES-1:0]       in_is_cmov,
  input logic [LANES*REG_W-1:0] in_src_a,
  input logic [LANES*REG_W-1:0] in_src_b,
  input logic [LANES*REG_W-1:0] in_dst,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES-1:0]       out_slot_valid,
  input logic [2*LANES-1:0]     out_kind,
  input logic [LANES*REG_W-1:0] out_src_a,
  input logic [LANES*REG_W-1:0] out_src_b,
  input logic [LANES*REG_W-1:0] out_dst,
  input logic [LANES-1:0]       out_b_old_dst,
  input logic                   out_last
);
  logic [LANES-1:0] first_at;
  always_comb begin
    for (int s = 0; s < LANES; s++)
      first_at[s] = out_slot_valid[s] && (out_kind[2*s +: 2] == 2'd1);
  end

  // R6: the final group and only the final group lacks a first part
  assert_last_iff_no_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (first_at == '0)));

  // R5: at most one first part per group
  assert_one_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(first_at));

  // R5: a non-final group is followed by a group opening with a second part
  assert_next_opens_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_slot_valid[0] && out_kind[1:0] == 2'd2));

  // R7: held outputs during back-pressure
  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_slot_valid) && $stable(out_kind) &&
       $stable(out_src_a) && $stable(out_src_b) && $stable(out_dst) &&
       $stable(out_b_old_dst) && $stable(out_last)));

  // R8: taking a line drops in_ready
  assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && out_valid));

  // R8: final acceptance reopens the input
  assert_reopen_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);

  for (genvar s = 0; s < LANES; s++) begin : g_slot
    // R3: first part reads old destination mapping, marker set only there
    assert_first_operands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_slot_valid[s]) |->
        (out_b_old_dst[s] == (out_kind[2*s +: 2] == 2'd1)) &&
        ((out_kind[2*s +: 2] != 2'd1) ||
         (out_src_b[s*REG_W +: REG_W] == out_dst[s*REG_W +: REG_W])));

    // R4: second part reads the destination it rewrites
    assert_second_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_slot_valid[s] && out_kind[2*s +: 2] == 2'd2) |->
        (out_src_a[s*REG_W +: REG_W] == out_dst[s*REG_W +: REG_W]));

    // R9: empty slots are zero
    assert_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_slot_valid[s]) |->
        (out_kind[2*s +: 2] == 2'd0 && !out_b_old_dst[s] &&
         out_src_a[s*REG_W +: REG_W] == '0 && out_src_b[s*REG_W +: REG_W] == '0 &&
         out_dst[s*REG_W +: REG_W] == '0));

    if (s > 0) begin : g_tail
      // R5: a second part only ever opens a group
      assert_second_in_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_slot_valid[s]) |-> (out_kind[2*s +: 2] != 2'd2));
    end
    if (s < LANES - 1) begin : g_close
      // R5: nothing follows a first part inside its group
      assert_close_after_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && first_at[s]) |-> !out_slot_valid[s+1]);
    end
  end
endmodule

bind cmg_grouper cmg_grouper_chk #(.LANES(LANES), .REG_W(REG_W)) u_chk (.*);

// File: tb/cmg_grouper_bench.sv
module cmg_grouper_bench;
  localparam int LANES = 4;
  localparam int REG_W = 5;
  localparam int MAXG  = LANES + 1;
  localparam int RMASK = (1 << REG_W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                   rst_n;
  logic                   in_valid;
  logic                   in_ready;
  logic [LANES-1:0]       in_lane_valid;
  logic [LANES-1:0]       in_is_cmov;
  logic [LANES*REG_W-1:0] in_src_a;
  logic [LANES*REG_W-1:0] in_src_b;
  logic [LANES*REG_W-1:0] in_dst;
  logic                   out_valid;
  logic                   out_ready;
  logic [LANES-1:0]       out_slot_valid;
  logic [2*LANES-1:0]     out_kind;
  logic [LANES*REG_W-1:0] out_src_a;
  logic [LANES*REG_W-1:0] out_src_b;
  logic [LANES*REG_W-1:0] out_dst;
  logic [LANES-1:0]       out_b_old_dst;
  logic                   out_last;

  cmg_grouper #(.LANES(LANES), .REG_W(REG_W)) u_cmg_grouper (.*);

  int n_tests = 0;
  int n_fail  = 0;

  int e_v [MAXG][LANES];
  int e_k [MAXG][LANES];
  int e_a [MAXG][LANES];
  int e_b [MAXG][LANES];
  int e_d [MAXG][LANES];
  int e_m [MAXG][LANES];
  int n_grp;

  logic [7:0] lfsr = 8'hA5;
  logic [LANES + 2*LANES + 3*LANES*REG_W + LANES:0] snap;

  function automatic int opa(int l, int j); return (l*5 + j*3 + 1) & RMASK; endfunction
  function automatic int opb(int l, int j); return (l*7 + j*11 + 2) & RMASK; endfunction
  function automatic int opc(int l, int j); return (l*13 + j*5 + 3) & RMASK; endfunction

  function automatic logic [LANES + 2*LANES + 3*LANES*REG_W + LANES:0] grab();
    return {out_slot_valid, out_kind, out_src_a, out_src_b, out_dst, out_b_old_dst, out_last};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // line encoding: bits [3:0] lane-valid, bits [7:4] conditional-move flags
  task automatic build_expected(input int l);
    int g, s;
    for (int gi = 0; gi < MAXG; gi++)
      for (int si = 0; si < LANES; si++) begin
        e_v[gi][si] = 0; e_k[gi][si] = 0; e_a[gi][si] = 0;
        e_b[gi][si] = 0; e_d[gi][si] = 0; e_m[gi][si] = 0;
      end
    g = 0; s = 0;
    for (int j = 0; j < LANES; j++) begin
      if (((l >> j) & 1) == 1) begin
        e_v[g][s] = 1; e_a[g][s] = opa(l, j); e_d[g][s] = opc(l, j);
        if (((l >> (4 + j)) & 1) == 1) begin
          e_k[g][s] = 1; e_b[g][s] = opc(l, j); e_m[g][s] = 1;
          g++;
          e_v[g][0] = 1; e_k[g][0] = 2; e_a[g][0] = opc(l, j);
          e_b[g][0] = opb(l, j); e_d[g][0] = opc(l, j);
          s = 1;
        end else begin
          e_k[g][s] = 0; e_b[g][s] = opb(l, j);
          s++;
        end
      end
    end
    n_grp = g + 1;
  endtask

  task automatic drive_line(input int l, input bit junk);
    in_valid = 1'b1;
    for (int j = 0; j < LANES; j++) begin
      in_lane_valid[j] = junk ? ~l[j]     : l[j];
      in_is_cmov[j]    = junk ? ~l[4 + j] : l[4 + j];
      in_src_a[j*REG_W +: REG_W] = REG_W'(junk ? ~opa(l, j) : opa(l, j));
      in_src_b[j*REG_W +: REG_W] = REG_W'(junk ? ~opb(l, j) : opb(l, j));
      in_dst[j*REG_W +: REG_W]   = REG_W'(junk ? ~opc(l, j) : opc(l, j));
    end
  endtask

  task automatic compare_group(input int g, input int l);
    for (int s = 0; s < LANES; s++) begin
      int act, exp;
      string req;
      act = {out_slot_valid[s], out_kind[2*s +: 2], out_src_a[s*REG_W +: REG_W],
             out_src_b[s*REG_W +: REG_W], out_dst[s*REG_W +: REG_W], out_b_old_dst[s]};
      exp = (e_v[g][s] << (3 + 3*REG_W)) | (e_k[g][s] << (1 + 3*REG_W)) |
            (e_a[g][s] << (1 + 2*REG_W)) | (e_b[g][s] << (1 + REG_W)) |
            (e_d[g][s] << 1) | e_m[g][s];
      if (e_v[g][s] == 0)      req = ((l & 15) == 0) ? "R10" : "R9";
      else if (e_k[g][s] == 0) req = ((l >> 4) & (l & 15)) == 0 ? "R2" : "R5";
      else if (e_k[g][s] == 1) req = "R3";
      else                     req = "R4";
      check(act == exp, req, $sformatf("line %0h group %0d slot %0d", l, g, s), act, exp);
    end
    check(out_last == (g == n_grp - 1), "R6",
          $sformatf("line %0h group %0d last", l, g), int'(out_last), int'(g == n_grp - 1));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_lane_valid = '0; in_is_cmov = '0; in_src_a = '0; in_src_b = '0; in_dst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    for (int l = 0; l < 256; l++) begin
      int g, guard;
      bit stalled;
      build_expected(l);
      check(in_ready == 1'b1, "R8", $sformatf("line %0h offered, in_ready", l), int'(in_ready), 1);
      drive_line(l, 1'b0);
      @(negedge clk);
      if (l % 2 == 1) drive_line(l, 1'b1);   // competing offer while busy
      else in_valid = 1'b0;
      g = 0; guard = 0; stalled = 1'b0;
      while (g < n_grp) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = lfsr[0] | lfsr[1];
        check(in_ready == 1'b0, "R8", $sformatf("line %0h busy, in_ready", l), int'(in_ready), 0);
        if (stalled)
          check(grab() == snap, "R7", $sformatf("line %0h group %0d held", l, g), 0, 0);
        check(out_valid == 1'b1, "R6", $sformatf("line %0h group %0d valid", l, g), int'(out_valid), 1);
        if (out_ready) begin
          compare_group(g, l);
          g++;
          stalled = 1'b0;
        end else begin
          snap = grab();
          stalled = 1'b1;
        end
        guard++;
        if (guard > 64) begin
          check(1'b0, "R6", $sformatf("watchdog line %0h", l), g, n_grp);
          g = n_grp;
        end
        @(negedge clk);
      end
      out_ready = 1'b0;
      check(out_valid == 1'b0, "R6", $sformatf("line %0h extra group", l), int'(out_valid), 0);
    end
    in_valid = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog R8: actual %0d cycles expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end
endmodule